// File: doc/BRIEF.md
# Lock-Guarded Double Frame Buffer

This block is a two-bank frame buffer. It sits between a stream-fed writer and a block consumer. Each bank has its own hardware lock, which moves around a fixed ring: FREE, then held for writing, then FULL, then held for reading, then FREE again. The writer side accepts 32-bit beats with a valid/ready handshake. It takes the write lock on a bank, fills the bank with one frame, and releases the lock so the bank becomes FULL. It then moves on to the other bank. When the writer wraps around to a bank that has not yet been drained, it waits in a lock-request state and counts the cycles it is stalled.

The consumer side raises a request and takes the read lock on its current input bank. It then asks a downstream party for the write lock on that party's output bank. A start gate opens only when both locks are held. While the gate is open, the consumer reads the frame at random addresses. A done strobe then releases the downstream output lock and frees the input bank. Every lock acquire and every lock release spends a fixed, parameterised number of overhead cycles. A separate stall counter on each side makes back-pressure visible.

Top module: `lock_pingpong`

## Requirements
- R1: While reset is low, both lock codes are FREE (0), `in_ready`, `cons_go`, `cons_stall`, `out_lock_req` and `out_lock_rel` are 0, both bank pointers are 0, and both stall counters are 0.
- R2: The writer fills bank 0, then bank 1, then bank 0, and so on. `in_ready` is high only while the writer's bank (`wr_bank`) holds lock code WRITE_HELD (1). Both banks are never WRITE_HELD at the same time.
- R3: A frame is FRAME_WORDS beats (32 by default). A beat is taken only on a clock edge where `in_valid` and `in_ready` are both high, and it is stored at the next word position. Beats offered while `in_ready` is low are dropped. After the last beat of a frame, the bank becomes FULL (2).
- R4: When the writer returns to a bank that is not FREE, `in_ready` stays low and `wr_stall_cnt` rises by exactly one per cycle. Filling resumes only after that bank has been freed. The counter does not move while the writer is filling.
- R5: With `cons_req` high and the input bank (`rd_bank`) FULL, the block takes that bank's read lock, and the bank's code becomes READ_HELD (3). While the input bank is not FULL, `cons_stall` is high and `rd_stall_cnt` rises by one per cycle.
- R6: `cons_go` is high only while the input bank is READ_HELD and `out_lock_gnt` is high. While the read lock is held but the grant is missing, `out_lock_req` and `cons_stall` are high, `cons_go` is low, and `rd_stall_cnt` rises by one per cycle.
- R7: While `cons_go` is high, `rd_data` one cycle after `rd_addr` is presented is the word that arrived at position `rd_addr` of the frame held in the input bank.
- R8: `cons_done` during a run gives a single-cycle `out_lock_rel`. After the release overhead, the input bank returns to FREE and `rd_bank` toggles. `cons_done` outside a run changes no lock code and gives no `out_lock_rel`.
- R9: Lock overhead is LOCK_OVH cycles (2 by default). The bank becomes FULL exactly LOCK_OVH edges after the edge that takes the frame's last beat. The bank becomes FREE exactly LOCK_OVH edges after the edge that samples `cons_done`.
- R10: In each bank, the lock code only stays the same or moves one step along the ring FREE→WRITE_HELD→FULL→READ_HELD→FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 32 | Stream beat data |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Writer can accept a beat |
| wr_bank | output | 1 | Bank the writer targets |
| cons_req | input | 1 | Consumer asks for its input bank |
| out_lock_gnt | input | 1 | Downstream output-bank lock granted |
| out_lock_req | output | 1 | Request for downstream output-bank lock |
| out_lock_rel | output | 1 | One-cycle release of downstream output-bank lock |
| cons_go | output | 1 | Start gate: both locks held |
| cons_stall | output | 1 | Consumer lock stall |
| cons_done | input | 1 | Consumer finished with the frame |
| rd_bank | output | 1 | Consumer input bank |
| rd_addr | input | 5 | Word address inside the input frame |
| rd_data | output | 32 | Registered read data |
| bank_lock | output | 4 | Lock codes, bank 0 in [1:0], bank 1 in [3:2] |
| wr_stall_cnt | output | 16 | Writer lock-stall cycles |
| rd_stall_cnt | output | 16 | Consumer lock-stall cycles |

## Verification
The assertions check several rules on every cycle. The handshake is never ready without a write lock, and the two banks are never both written at once. Each bank's lock code only advances around its ring. The start gate never opens without both locks, and it is never open while a stall is reported. The writer stall count stays frozen while data flows, and the downstream release is a single pulse. Only the bench scenarios can show frame contents arriving intact in arrival order, dropped beats when ready is low, exact stall counts over timed waits, and the exact overhead latency of each lock change.

// File: rtl/ppb_pkg.sv
// Shared types for the lock-guarded double frame buffer.
// Assumes exactly two banks; lock codes advance by +1 modulo 4.
package ppb_pkg;
    localparam int NBANK = 2;

    typedef enum logic [1:0] {
        LK_FREE  = 2'd0,
        LK_WRITE = 2'd1,
        LK_FULL  = 2'd2,
        LK_READ  = 2'd3
    } lock_e;

    typedef enum logic [1:0] {
        W_REQ, W_ACQ, W_FILL, W_REL
    } wr_st_e;

    typedef enum logic [2:0] {
        R_REQ, R_ACQ, R_WAIT, R_RUN, R_REL
    } rd_st_e;
endpackage

// File: rtl/ppb_lock_table.sv
// Per-bank lock registers. Writer grabs/releases, reader grabs/releases.
// Assumes callers only grab a bank in the proper prior state
// (writer from FREE, reader from FULL), so no two commands collide.
module ppb_lock_table
    import ppb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_grab,
    input  logic                 wr_rel,
    input  logic                 wr_sel,
    input  logic                 rd_grab,
    input  logic                 rd_rel,
    input  logic                 rd_sel,
    output logic [2*NBANK-1:0]   lock_vec
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        lock_e st;

        // Advance this bank's lock code on the command that addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                st <= LK_FREE;
            else if (wr_grab && (wr_sel == 1'(b)))     st <= LK_WRITE;
            else if (wr_rel  && (wr_sel == 1'(b)))     st <= LK_FULL;
            else if (rd_grab && (rd_sel == 1'(b)))     st <= LK_READ;
            else if (rd_rel  && (rd_sel == 1'(b)))     st <= LK_FREE;
        end

        assign lock_vec[2*b +: 2] = st;
    end
endmodule

// File: rtl/ppb_bank_mem.sv
// Two-bank storage, one write port and one registered read port.
// Assumes FRAME_WORDS is a power of two so {bank, index} is dense.
module ppb_bank_mem #(
    parameter int DATA_W      = 32,
    parameter int FRAME_WORDS = 32,
    localparam int ADDR_W     = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wbank,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 2 * FRAME_WORDS;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted beat.
    always_ff @(posedge clk) begin
        if (we) mem[{wbank, waddr}] <= wdata;
    end

    // Registered read of the consumer's bank.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[{rbank, raddr}];
    end
endmodule

// File: rtl/ppb_wr_ctrl.sv
// Writer side: request, acquire (LOCK_OVH cycles), fill one frame,
// release (LOCK_OVH cycles), then switch bank. Counts lock-stall cycles.
// Assumes LOCK_OVH >= 1.
module ppb_wr_ctrl
    import ppb_pkg::*;
#(
    parameter int FRAME_WORDS = 32,
    parameter int LOCK_OVH    = 2,
    parameter int CNT_W       = 16,
    localparam int ADDR_W     = $clog2(FRAME_WORDS),
    localparam int OVH_W      = (LOCK_OVH > 1) ? $clog2(LOCK_OVH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  lock_e             lock_cur,
    output logic              in_ready,
    output logic              bank,
    output logic [ADDR_W-1:0] idx,
    output logic              wr_en,
    output logic              grab,
    output logic              rel,
    output logic [CNT_W-1:0]  stall_cnt
);
    wr_st_e           st;
    logic [OVH_W-1:0] cnt;

    // Writer sequencing and stall counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= W_REQ;
            bank      <= 1'b0;
            idx       <= '0;
            cnt       <= '0;
            stall_cnt <= '0;
        end else begin
            case (st)
                W_REQ: begin
                    if (lock_cur == LK_FREE) begin
                        st  <= W_ACQ;
                        cnt <= OVH_W'(LOCK_OVH - 1);
                    end else begin
                        stall_cnt <= stall_cnt + 1'b1;
                    end
                end
                W_ACQ: begin
                    if (cnt == '0) begin
                        st  <= W_FILL;
                        idx <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                W_FILL: begin
                    if (in_valid) begin
                        idx <= idx + 1'b1;
                        if (idx == ADDR_W'(FRAME_WORDS - 1)) begin
                            st  <= W_REL;
                            cnt <= OVH_W'(LOCK_OVH - 1);
                        end
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st   <= W_REQ;
                        bank <= ~bank;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Handshake and lock commands decoded from state.
    always_comb begin
        in_ready = (st == W_FILL);
        wr_en    = in_ready && in_valid;
        grab     = (st == W_ACQ) && (cnt == '0);
        rel      = (st == W_REL) && (cnt == '0);
    end
endmodule

// File: rtl/ppb_rd_ctrl.sv
// Consumer side: take the input bank's read lock, wait for the
// downstream output lock, open the start gate, release on done.
// Assumes LOCK_OVH >= 1 and that the grant is held until release.
module ppb_rd_ctrl
    import ppb_pkg::*;
#(
    parameter int LOCK_OVH = 2,
    parameter int CNT_W    = 16,
    localparam int OVH_W   = (LOCK_OVH > 1) ? $clog2(LOCK_OVH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cons_req,
    input  logic             cons_done,
    input  logic             out_lock_gnt,
    input  lock_e            lock_cur,
    output logic             bank,
    output logic             grab,
    output logic             rel,
    output logic             cons_go,
    output logic             cons_stall,
    output logic             out_lock_req,
    output logic             out_lock_rel,
    output logic [CNT_W-1:0] stall_cnt
);
    rd_st_e           st;
    logic [OVH_W-1:0] cnt;

    // Consumer sequencing and stall counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= R_REQ;
            bank      <= 1'b0;
            cnt       <= '0;
            stall_cnt <= '0;
        end else begin
            if (cons_stall) stall_cnt <= stall_cnt + 1'b1;
            case (st)
                R_REQ: begin
                    if (cons_req && (lock_cur == LK_FULL)) begin
                        st  <= R_ACQ;
                        cnt <= OVH_W'(LOCK_OVH - 1);
                    end
                end
                R_ACQ: begin
                    if (cnt == '0) st  <= R_WAIT;
                    else           cnt <= cnt - 1'b1;
                end
                R_WAIT: begin
                    if (out_lock_gnt) st <= R_RUN;
                end
                R_RUN: begin
                    if (cons_done) begin
                        st  <= R_REL;
                        cnt <= OVH_W'(LOCK_OVH - 1);
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st   <= R_REQ;
                        bank <= ~bank;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // Gate, stall flag and lock commands decoded from state.
    always_comb begin
        grab         = (st == R_ACQ) && (cnt == '0);
        rel          = (st == R_REL) && (cnt == '0);
        cons_go      = (st == R_RUN);
        out_lock_req = (st == R_WAIT) || (st == R_RUN);
        out_lock_rel = (st == R_RUN) && cons_done;
        cons_stall   = ((st == R_REQ) && cons_req && (lock_cur != LK_FULL))
                    || ((st == R_WAIT) && !out_lock_gnt);
    end
endmodule

// File: rtl/lock_pingpong.sv
// Top: double frame buffer with one acquire/release lock per bank.
// Assumes FRAME_WORDS is a power of two and LOCK_OVH >= 1.
module lock_pingpong
    import ppb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int FRAME_WORDS = 32,
    parameter int LOCK_OVH    = 2,
    parameter int CNT_W       = 16,
    localparam int ADDR_W     = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              wr_bank,
    input  logic              cons_req,
    input  logic              out_lock_gnt,
    output logic              out_lock_req,
    output logic              out_lock_rel,
    output logic              cons_go,
    output logic              cons_stall,
    input  logic              cons_done,
    output logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [3:0]        bank_lock,
    output logic [CNT_W-1:0]  wr_stall_cnt,
    output logic [CNT_W-1:0]  rd_stall_cnt
);
    logic [2*NBANK-1:0] lock_vec;
    logic [ADDR_W-1:0]  wr_idx;
    logic               wr_en, wr_grab, wr_rel, rd_grab, rd_rel;
    lock_e              wr_lock, rd_lock;

    // Pick the lock code each side is looking at.
    always_comb begin
        wr_lock   = lock_e'(lock_vec[{wr_bank, 1'b0} +: 2]);
        rd_lock   = lock_e'(lock_vec[{rd_bank, 1'b0} +: 2]);
        bank_lock = lock_vec;
    end

    ppb_lock_table u_locks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_grab  (wr_grab),
        .wr_rel   (wr_rel),
        .wr_sel   (wr_bank),
        .rd_grab  (rd_grab),
        .rd_rel   (rd_rel),
        .rd_sel   (rd_bank),
        .lock_vec (lock_vec)
    );

    ppb_wr_ctrl #(
        .FRAME_WORDS (FRAME_WORDS),
        .LOCK_OVH    (LOCK_OVH),
        .CNT_W       (CNT_W)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .lock_cur  (wr_lock),
        .in_ready  (in_ready),
        .bank      (wr_bank),
        .idx       (wr_idx),
        .wr_en     (wr_en),
        .grab      (wr_grab),
        .rel       (wr_rel),
        .stall_cnt (wr_stall_cnt)
    );

    ppb_rd_ctrl #(
        .LOCK_OVH (LOCK_OVH),
        .CNT_W    (CNT_W)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cons_req     (cons_req),
        .cons_done    (cons_done),
        .out_lock_gnt (out_lock_gnt),
        .lock_cur     (rd_lock),
        .bank         (rd_bank),
        .grab         (rd_grab),
        .rel          (rd_rel),
        .cons_go      (cons_go),
        .cons_stall   (cons_stall),
        .out_lock_req (out_lock_req),
        .out_lock_rel (out_lock_rel),
        .stall_cnt    (rd_stall_cnt)
    );

    ppb_bank_mem #(
        .DATA_W      (DATA_W),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wbank (wr_bank),
        .waddr (wr_idx),
        .wdata (in_data),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/lock_pingpong_chk.sv
// Cycle-by-cycle rules on the double frame buffer, bound to the top.
module lock_pingpong_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             wr_bank,
    input logic             rd_bank,
    input logic             cons_go,
    input logic             cons_stall,
    input logic             out_lock_gnt,
    input logic             out_lock_rel,
    input logic [3:0]       bank_lock,
    input logic [CNT_W-1:0] wr_stall_cnt,
    input logic [CNT_W-1:0] rd_stall_cnt
);
    logic [1:0] lk0, lk1, lk_wr, lk_rd;
    assign lk0   = bank_lock[1:0];
    assign lk1   = bank_lock[3:2];
    assign lk_wr = wr_bank ? lk1 : lk0;
    assign lk_rd = rd_bank ? lk1 : lk0;

    AST_READY_NEEDS_WLOCK: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (lk_wr == 2'd1)); // R2
    AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !((lk0 == 2'd1) && (lk1 == 2'd1))); // R2
    AST_WSTALL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) in_ready |=> (wr_stall_cnt == $past(wr_stall_cnt))); // R4
    AST_RSTALL_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((rd_stall_cnt == $past(rd_stall_cnt)) || (rd_stall_cnt == CNT_W'($past(rd_stall_cnt) + 1'b1)))); // R5
    AST_GO_NEEDS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n) cons_go |-> ((lk_rd == 2'd3) && out_lock_gnt)); // R6
    AST_STALL_NOT_GO: assert property (@(posedge clk) disable iff (!rst_n) cons_stall |-> !cons_go); // R6
    AST_REL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) out_lock_rel |=> !out_lock_rel); // R8
    AST_LOCK_RING0: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((lk0 == $past(lk0)) || (lk0 == 2'($past(lk0) + 2'd1)))); // R10
    AST_LOCK_RING1: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((lk1 == $past(lk1)) || (lk1 == 2'($past(lk1) + 2'd1)))); // R10
endmodule

bind lock_pingpong lock_pingpong_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .wr_bank      (wr_bank),
    .rd_bank      (rd_bank),
    .cons_go      (cons_go),
    .cons_stall   (cons_stall),
    .out_lock_gnt (out_lock_gnt),
    .out_lock_rel (out_lock_rel),
    .bank_lock    (bank_lock),
    .wr_stall_cnt (wr_stall_cnt),
    .rd_stall_cnt (rd_stall_cnt)
);

// File: tb/lock_pingpong_test.sv
module lock_pingpong_test;
    localparam int FW   = 32;
    localparam int OVH  = 2;
    localparam int NFR  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, wr_bank;
    logic        cons_req = 1'b0, out_lock_gnt = 1'b0, cons_done = 1'b0;
    logic        out_lock_req, out_lock_rel, cons_go, cons_stall, rd_bank;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  bank_lock;
    logic [15:0] wr_stall_cnt, rd_stall_cnt;

    int checks = 0;
    int fails  = 0;
    int ring_bad = 0;
    logic [31:0] expf [NFR][FW];
    logic [1:0]  prev_lk [2];

    always #2 clk = ~clk;

    lock_pingpong #(.LOCK_OVH(OVH)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .wr_bank(wr_bank), .cons_req(cons_req),
        .out_lock_gnt(out_lock_gnt), .out_lock_req(out_lock_req),
        .out_lock_rel(out_lock_rel), .cons_go(cons_go), .cons_stall(cons_stall),
        .cons_done(cons_done), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(rd_data), .bank_lock(bank_lock),
        .wr_stall_cnt(wr_stall_cnt), .rd_stall_cnt(rd_stall_cnt)
    );

    function automatic logic [1:0] lk(input int b);
        return bank_lock[2*b +: 2];
    endfunction

    function automatic bit ring_ok(input logic [1:0] a, input logic [1:0] b);
        return (b == a) || (b == 2'(a + 2'd1));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10 monitor: each bank's code only holds or steps along the ring.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_lk[0] <= 2'd0;
            prev_lk[1] <= 2'd0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (!ring_ok(prev_lk[b], lk(b))) ring_bad++;
                prev_lk[b] <= lk(b);
            end
        end
    end

    task automatic send_frame(input int f);
        int acc = 0;
        bit vld;
        logic [31:0] d;
        while (acc < FW) begin
            @(negedge clk);
            if (in_ready && acc == 0) begin
                chk(wr_bank == 1'(f % 2), "R2 writer bank order", 64'(wr_bank), 64'(f % 2));
                chk(lk(f % 2) == 2'd1, "R2 write lock held while ready", 64'(lk(f % 2)), 64'd1);
            end
            vld = ($urandom % 4) != 0;
            d   = $urandom;
            in_valid = vld;
            in_data  = d;
            if (in_ready && vld) begin
                expf[f][acc] = d;
                acc++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hDEAD_BEEF;
        chk(lk(f % 2) == 2'd1, "R9 lock still write-held after last beat", 64'(lk(f % 2)), 64'd1);
        repeat (OVH - 1) begin
            @(negedge clk);
            chk(lk(f % 2) == 2'd1, "R9 release overhead not yet over", 64'(lk(f % 2)), 64'd1);
        end
        @(negedge clk);
        chk(lk(f % 2) == 2'd2, "R3 R9 bank full after release", 64'(lk(f % 2)), 64'd2);
    endtask

    task automatic consume(input int f);
        int rb = f % 2;
        int t = 0;
        int g;
        logic [15:0] c0;
        int a;
        @(negedge clk);
        cons_req = 1'b1;
        out_lock_gnt = 1'b0;
        while (!out_lock_req && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(rd_bank == 1'(rb), "R5 consumer bank order", 64'(rd_bank), 64'(rb));
        chk(lk(rb) == 2'd3, "R5 read lock taken", 64'(lk(rb)), 64'd3);
        chk(!cons_go && cons_stall, "R6 gate closed without output lock", {62'd0, cons_go, cons_stall}, 64'd1);
        cons_req = 1'b0;
        c0 = rd_stall_cnt;
        g = 1 + int'($urandom % 4);
        repeat (g) @(negedge clk);
        chk(rd_stall_cnt == 16'(c0 + g), "R6 stall count while grant missing", 64'(rd_stall_cnt), 64'(c0 + g));
        out_lock_gnt = 1'b1;
        @(negedge clk);
        chk(cons_go && !cons_stall, "R6 gate open with both locks", {62'd0, cons_go, cons_stall}, 64'd2);
        for (int i = 0; i < FW; i++) begin
            a = (i * 5 + f) % FW;
            rd_addr = 5'(a);
            @(negedge clk);
            chk(rd_data == expf[f][a], "R7 read data", 64'(rd_data), 64'(expf[f][a]));
        end
        cons_done = 1'b1;
        #1;
        chk(out_lock_rel == 1'b1, "R8 downstream release pulse", 64'(out_lock_rel), 64'd1);
        @(negedge clk);
        cons_done = 1'b0;
        out_lock_gnt = 1'b0;
        chk(out_lock_rel == 1'b0 && lk(rb) == 2'd3, "R8 R9 pulse ends, lock still held", {61'd0, out_lock_rel, lk(rb)}, 64'd3);
        repeat (OVH - 1) @(negedge clk);
        chk(lk(rb) == 2'd3, "R9 read release overhead", 64'(lk(rb)), 64'd3);
        @(negedge clk);
        chk(lk(rb) == 2'd0, "R8 R9 input bank freed", 64'(lk(rb)), 64'd0);
        chk(rd_bank == 1'(1 - rb), "R8 consumer bank toggles", 64'(rd_bank), 64'(1 - rb));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] c0;
        logic [1:0]  l0, l1;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bank_lock == 4'd0, "R1 locks free", 64'(bank_lock), 64'd0);
        chk(!in_ready && !cons_go && !cons_stall && !out_lock_req && !out_lock_rel, "R1 controls low",
            {59'd0, in_ready, cons_go, cons_stall, out_lock_req, out_lock_rel}, 64'd0);
        chk(!wr_bank && !rd_bank, "R1 bank pointers", {62'd0, wr_bank, rd_bank}, 64'd0);
        chk(wr_stall_cnt == 0 && rd_stall_cnt == 0, "R1 counters", {wr_stall_cnt, rd_stall_cnt}, 64'd0);
        rst_n = 1'b1;

        // R5: consumer asks before any data exists
        @(negedge clk);
        cons_req = 1'b1;
        c0 = rd_stall_cnt;
        repeat (5) begin
            @(negedge clk);
            chk(cons_stall && !cons_go, "R5 stall flag on missing data", {62'd0, cons_stall, cons_go}, 64'd2);
        end
        chk(rd_stall_cnt == 16'(c0 + 5), "R5 stall count on missing data", 64'(rd_stall_cnt), 64'(c0 + 5));
        cons_req = 1'b0;
        @(negedge clk);
        c0 = rd_stall_cnt;
        l0 = lk(0);
        l1 = lk(1);
        // R8: done outside a run is ignored
        cons_done = 1'b1;
        #1;
        chk(out_lock_rel == 1'b0, "R8 no release pulse outside run", 64'(out_lock_rel), 64'd0);
        @(negedge clk);
        cons_done = 1'b0;
        repeat (2) @(negedge clk);
        chk(lk(0) == l0 && lk(1) == l1 && rd_bank == 1'b0, "R8 stray done ignored",
            {59'd0, lk(1), lk(0), rd_bank}, {59'd0, l1, l0, 1'b0});
        chk(rd_stall_cnt == c0, "R5 no stall without request", 64'(rd_stall_cnt), 64'(c0));

        send_frame(0);
        send_frame(1);

        // R4: writer wrapped onto a full bank
        c0 = wr_stall_cnt;
        repeat (6) begin
            @(negedge clk);
            chk(!in_ready, "R4 writer held off", 64'(in_ready), 64'd0);
        end
        chk(wr_stall_cnt == 16'(c0 + 6), "R4 writer stall count", 64'(wr_stall_cnt), 64'(c0 + 6));
        chk(lk(0) == 2'd2, "R4 target bank still full", 64'(lk(0)), 64'd2);

        for (int f = 0; f < NFR; f++) begin
            consume(f);
            if (f + 2 < NFR) send_frame(f + 2);
        end

        chk(ring_bad == 0, "R10 lock ring order", 64'(ring_bad), 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule